// File: doc/BRIEF.md
# Burst Interval Timestamp Recorder

This block watches a disk read as it streams through a DMA engine and records how long each 16-byte burst takes. A divided reference clock drives an 8-bit wrapping tick counter. With a 2.4576 MHz reference and a divide ratio of 10, one tick is about 4.07 µs and the counter wraps about every 1042 µs. At the nominal rate of one byte per 32 µs, a 16-byte burst lasts about 512 µs, or close to 128 ticks (0x80). That places the usual sample near the middle of a byte, which makes a byte-wide record easy to read.

A run starts with a one-cycle `arm` command. The arm restarts the time base, clears the record and waits for the first data request from the disk controller. The tick value at that request is held as the first-byte stamp. After that, every rising edge of the address-advance line stores one byte: the number of ticks since the previous capture, modulo 256. The first stored interval also includes bus grant, burst and release time, so a per-run adjustment value is subtracted from that interval only. The run ends on the rising edge of the controller's end-of-command interrupt.

The three event inputs are asynchronous. Each passes through a two-stage synchronizer and a rising-edge detector. The samples are read back through a simple address/data port.

Top module: `burst_stamp_rec`

## Requirements
- R1: After reset, `sample_count` is 0 and `full`, `wrap_sat`, `done` and `busy` are all 0.
- R2: `arm` restarts the prescaler and the tick counter at zero. The tick counter then advances once every PRESCALE (default 10) clock cycles and wraps modulo 256. An event input that is high at clock edge A+t, where edge A samples `arm`, is stamped with tick value floor((t+1)/PRESCALE) mod 256. This includes two synchronizer stages and one edge-detect stage.
- R3: The first rising `dreq_async` after arming loads `first_stamp` with its tick value. `first_stamp` then holds until the next arm.
- R4: While the run is active, each rising `adv_async` writes one byte at the next address, starting at 0. The byte is the current tick minus the tick of the previous capture, modulo 256.
- R5: Only for the first interval of a run (first data request to first address advance), `first_adj` is also subtracted, modulo 256.
- R6: An interval that crosses the tick counter's wrap from 255 to 0 is stored correctly as long as it is shorter than 256 ticks.
- R7: `wrap_sat` is set when 256 or more ticks pass between two captures. It stays set until the next arm.
- R8: An address advance before the first data request stores nothing. A data request after the first one has no effect.
- R9: A rising `irq_async` ends the run. `done` becomes 1, `busy` becomes 0, and later events store nothing.
- R10: After DEPTH (default 512) samples, `full` is 1. Further samples are discarded and `sample_count` stays at DEPTH.
- R11: `rd_data` returns the byte at `rd_addr` one clock after the address is presented.
- R12: `arm` clears `sample_count`, `full`, `wrap_sat` and `done`, and sets `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the reference for the tick prescaler |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | One-cycle start command |
| first_adj | input | 8 | Value subtracted from the first interval |
| dreq_async | input | 1 | Data request from the disk controller (asynchronous) |
| adv_async | input | 1 | DMA address advance, one per burst (asynchronous) |
| irq_async | input | 1 | End-of-command interrupt (asynchronous) |
| rd_addr | input | 9 | Sample read address |
| rd_data | output | 8 | Sample read data, one cycle later |
| sample_count | output | 10 | Number of samples stored (write pointer) |
| full | output | 1 | Record memory is full |
| wrap_sat | output | 1 | An interval of 256 ticks or more was seen |
| done | output | 1 | Run ended by the interrupt |
| busy | output | 1 | Armed and not yet done |
| first_stamp | output | 8 | Tick value at the first data request |

## Verification
An input raised at edge A+t reaches the capture logic after two synchronizer stages and one edge-detect stage. It is written at edge A+t+2, using the tick value held just before that edge. The bench therefore counts edges from the arm edge and predicts each stamp as floor((t+1)/10). Status outputs are sampled at falling edges several cycles after the last stimulus, so the write is complete. Read data is sampled one full cycle after `rd_addr` is set.

// File: rtl/burst_stamp_pkg.sv
package burst_stamp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_FIRST,
    ST_RUN,
    ST_DONE
  } rec_state_t;

  // modular tick difference with an extra subtracted adjustment
  function automatic logic [7:0] tick_delta(input logic [7:0] now_t,
                                            input logic [7:0] prev_t,
                                            input logic [7:0] adj);
    logic [7:0] r;
    r = now_t - prev_t - adj;
    return r;
  endfunction

endpackage

// File: rtl/tick_base.sv
module tick_base #(
  parameter int PRESCALE = 10,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic             tick_en,
  output logic [CNT_W-1:0] count
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre;

  assign tick_en = (pre == PLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      count <= '0;
    end else if (restart) begin
      pre   <= '0;
      count <= '0;
    end else if (tick_en) begin
      pre   <= '0;
      count <= count + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  generate
    if (PRESCALE > 1) begin : g_chk
      p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !restart) |=> !tick_en);
    end
  endgenerate

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !restart) |=> (count == $past(count) + 1'b1));

  p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));

endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] rise
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic s1, s2, s3;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1 <= 1'b0;
          s2 <= 1'b0;
          s3 <= 1'b0;
        end else begin
          s1 <= async_in[i];
          s2 <= s1;
          s3 <= s2;
        end
      end
      assign rise[i] = s2 & ~s3;

      p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise[i] |=> !rise[i]);
    end
  endgenerate

endmodule

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import burst_stamp_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] adj,
  input  logic             dreq_rise,
  input  logic             adv_rise,
  input  logic             done_rise,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] tick_cnt,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [7:0]       wdata,
  output logic [AW:0]      wr_ptr,
  output logic             full,
  output logic             sat,
  output logic             done,
  output logic             busy,
  output logic [CNT_W-1:0] first_stamp
);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  rec_state_t     state;
  logic [CNT_W-1:0] prev;
  logic           first_pend;
  logic [CNT_W:0] elapsed;

  // named internal events
  logic cap_first, cap_adv, stop_ev, span_over;

  assign stop_ev   = done_rise && (state == ST_WAIT_FIRST || state == ST_RUN);
  assign cap_first = (state == ST_WAIT_FIRST) && dreq_rise && !done_rise;
  assign cap_adv   = (state == ST_RUN) && adv_rise && !done_rise;
  assign span_over = elapsed[CNT_W];

  assign full  = (wr_ptr == CAP);
  assign we    = cap_adv && !full && !arm;
  assign waddr = wr_ptr[AW-1:0];
  assign wdata = tick_delta(8'(tick_cnt), 8'(prev), first_pend ? 8'(adj) : 8'd0);
  assign done  = (state == ST_DONE);
  assign busy  = (state == ST_WAIT_FIRST) || (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      prev        <= '0;
      first_pend  <= 1'b0;
      elapsed     <= '0;
      wr_ptr      <= '0;
      sat         <= 1'b0;
      first_stamp <= '0;
    end else if (arm) begin
      state       <= ST_WAIT_FIRST;
      prev        <= '0;
      first_pend  <= 1'b0;
      elapsed     <= '0;
      wr_ptr      <= '0;
      sat         <= 1'b0;
      first_stamp <= '0;
    end else begin
      if (stop_ev) state <= ST_DONE;
      if (cap_first) begin
        state       <= ST_RUN;
        first_stamp <= tick_cnt;
        prev        <= tick_cnt;
        first_pend  <= 1'b1;
        elapsed     <= (CNT_W+1)'(tick_en);
      end else if (cap_adv) begin
        prev       <= tick_cnt;
        first_pend <= 1'b0;
        elapsed    <= (CNT_W+1)'(tick_en);
        if (span_over) sat <= 1'b1;
        if (!full) wr_ptr <= wr_ptr + 1'b1;
      end else if (tick_en && !span_over) begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end

  p_ptr_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= CAP);

  p_full_blocks_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !we);

  p_done_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> $stable(wr_ptr));

  p_sat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !arm) |=> sat);

  p_arm_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (wr_ptr == '0 && !sat && busy));

  p_stamp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !arm) |=> $stable(first_stamp));

  p_no_write_before_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |-> !we);

endmodule

// File: rtl/record_mem.sv
module record_mem #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end

endmodule

// File: rtl/burst_stamp_rec.sv
module burst_stamp_rec #(
  parameter int DEPTH    = 512,
  parameter int PRESCALE = 10,
  localparam int CNT_W   = 8,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [7:0]    first_adj,
  input  logic          dreq_async,
  input  logic          adv_async,
  input  logic          irq_async,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [AW:0]   sample_count,
  output logic          full,
  output logic          wrap_sat,
  output logic          done,
  output logic          busy,
  output logic [7:0]    first_stamp
);
  logic             tick_en;
  logic [CNT_W-1:0] tick_cnt;
  logic [2:0]       rise;
  logic             we;
  logic [AW-1:0]    waddr;
  logic [7:0]       wdata;

  tick_base #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(arm),
    .tick_en(tick_en), .count(tick_cnt)
  );

  edge_sync #(.WIDTH(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({irq_async, adv_async, dreq_async}),
    .rise(rise)
  );

  stamp_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .adj(first_adj),
    .dreq_rise(rise[0]), .adv_rise(rise[1]), .done_rise(rise[2]),
    .tick_en(tick_en), .tick_cnt(tick_cnt),
    .we(we), .waddr(waddr), .wdata(wdata),
    .wr_ptr(sample_count), .full(full), .sat(wrap_sat),
    .done(done), .busy(busy), .first_stamp(first_stamp)
  );

  record_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

endmodule

// File: tb/sim_burst_stamp_rec.sv
module sim_burst_stamp_rec;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;
  localparam int PRE = 10;

  logic clk = 0, rst_n = 0, arm = 0;
  logic [7:0] first_adj = 0;
  logic dreq_async = 0, adv_async = 0, irq_async = 0;
  logic [8:0] rd_addr = 0;
  logic [7:0] rd_data, first_stamp;
  logic [9:0] sample_count;
  logic full, wrap_sat, done, busy;

  burst_stamp_rec u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  int t = 0;
  // bench model
  int m_state = 0; // 0 idle,1 wait,2 run,3 done
  int m_prev = 0, m_cnt = 0, m_first = 0;
  bit m_pend = 0, m_sat = 0;
  logic [7:0] m_mem [DEPTH];

  function automatic int abs_tick(int tt);
    return (tt + 1) / PRE;
  endfunction

  function automatic logic [7:0] model_delta(int now_a, int prev_a, int adj);
    return 8'((now_a - prev_a - adj) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    t += n;
  endtask

  task automatic do_arm(int adj);
    @(negedge clk);
    first_adj = 8'(adj);
    arm = 1;
    @(negedge clk);
    arm = 0;
    t = 1;
    m_state = 1; m_cnt = 0; m_sat = 0; m_pend = 0; m_first = 0; m_prev = 0;
  endtask

  task automatic ev_dreq(int gap);
    int a;
    step(gap);
    a = abs_tick(t);
    dreq_async = 1;
    if (m_state == 1) begin
      m_first = a & 255; m_prev = a; m_pend = 1; m_state = 2;
    end
    step(2);
    dreq_async = 0;
  endtask

  task automatic ev_adv(int gap);
    int a;
    step(gap);
    a = abs_tick(t);
    adv_async = 1;
    if (m_state == 2) begin
      if (a - m_prev >= 256) m_sat = 1;
      if (m_cnt < DEPTH) begin
        m_mem[m_cnt] = model_delta(a, m_prev, m_pend ? int'(first_adj) : 0);
        m_cnt++;
      end
      m_prev = a; m_pend = 0;
    end
    step(2);
    adv_async = 0;
  endtask

  task automatic ev_irq(int gap);
    step(gap);
    irq_async = 1;
    if (m_state == 1 || m_state == 2) m_state = 3;
    step(2);
    irq_async = 0;
  endtask

  task automatic check_status(string tag);
    step(4);
    chk(sample_count == 10'(m_cnt), {tag, " R4 count"}, sample_count, m_cnt);
    chk(full == (m_cnt == DEPTH), {tag, " R10 full"}, full, m_cnt == DEPTH);
    chk(wrap_sat == m_sat, {tag, " R7 sat"}, wrap_sat, m_sat);
    chk(done == (m_state == 3), {tag, " R9 done"}, done, m_state == 3);
    chk(busy == (m_state == 1 || m_state == 2), {tag, " R9 busy"}, busy, 0);
    if (m_state >= 2)
      chk(first_stamp == 8'(m_first), {tag, " R3 first_stamp"}, first_stamp, m_first);
  endtask

  task automatic check_mem(string tag, int lo, int hi);
    for (int i = lo; i < hi; i++) begin
      @(negedge clk); rd_addr = 9'(i);
      @(negedge clk);
      chk(rd_data == m_mem[i], {tag, " R4/R5/R11 sample"}, rd_data, m_mem[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(sample_count == 0, "R1 count", sample_count, 0);
    chk(!full && !wrap_sat && !done && !busy, "R1 flags",
        {full, wrap_sat, done, busy}, 0);

    // directed run: ignored events, offset, stop
    do_arm(16);
    chk(busy && !done && sample_count == 0, "R12 arm state", busy, 1);
    ev_adv(20);          // R8 advance before first request ignored
    ev_dreq(37);
    ev_adv(1290);        // first interval, R5 offset
    ev_adv(1275);
    ev_dreq(300);        // R8 extra request ignored
    ev_adv(1000);
    ev_adv(1311);
    ev_irq(50);
    ev_adv(500);         // R9 after stop ignored
    check_status("dir");
    check_mem("dir", 0, m_cnt);

    // wrap crossing R6, then saturation R7
    do_arm(0);
    chk(!done && sample_count == 0, "R12 rearm clears", sample_count, 0);
    ev_dreq(2000);
    ev_adv(1000);        // spans 255->0
    check_status("wrap");
    ev_adv(2700);        // 270 ticks -> R7
    check_status("sat");
    check_mem("wrap", 0, m_cnt);

    // random intervals
    do_arm(int'($urandom_range(0, 255)));
    chk(!wrap_sat, "R12 sat cleared", wrap_sat, 0);
    ev_dreq(int'($urandom_range(5, 2000)));
    for (int k = 0; k < 20; k++) ev_adv(int'($urandom_range(10, 2400)));
    ev_irq(10);
    check_status("rnd");
    check_mem("rnd", 0, m_cnt);

    // full R10
    do_arm(3);
    ev_dreq(9);
    for (int k = 0; k < DEPTH + 3; k++) ev_adv(int'($urandom_range(3, 12)));
    check_status("full");
    check_mem("full", 0, 4);
    check_mem("full", DEPTH - 4, DEPTH);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule